// File: doc/BRIEF.md
# SPI Byte Master with Status Flags

This block is a bus-attached serial master that moves one byte at a time over a four-wire synchronous serial link. A processor sees three byte-wide locations: control, status and data. Storing a byte into the data location, with the block enabled, starts a full-duplex exchange. The byte goes out on `mosi` most significant bit first while the same number of bits is gathered from `miso`. The select line `ssN` stays low for the whole exchange. All four combinations of clock idle level and sampling phase are supported, and four serial rates can be chosen.

When the eighth bit has been exchanged, a completion flag is raised, and the interrupt line follows that flag when interrupts are enabled. A store to the data location while an exchange is still running is refused and recorded as a collision. Software clears flags in two steps. A read of the status location notes which flags are up, and the next access to the data location clears exactly those flags.

Top module: `spi_byte_master`

## Requirements
- R1: Address 0 is the control register and reads back what was written. Its bits are [7] interrupt enable, [6] enable, [5] wire-or option, [4] master select, [3] clock idle level (cpol), [2] clock phase (cpha) and [1:0] rate. Address 1 is status and address 2 is data. Reads of address 3 return 0.
- R2: The status register holds [7] transfer-complete, [6] write-collision and [4] mode-fault, which is never set. All other bits read 0. Writes to status have no effect.
- R3: When the enable bit is 0, a write to the data register has no effect: no transfer starts, `ssN` stays high and no flag changes.
- R4: An accepted data write drives `ssN` low on the next clock edge. Eight bits then leave on `mosi`, most significant first, each lasting two half-periods with one `sck` toggle per half-period. `ssN` returns high exactly 17 half-periods after the write edge.
- R5: Rate 00, 01, 10 and 11 give a half-period of 1, 2, 8 and 16 clocks, that is an `sck` period of 2, 4, 16 and 32 clocks.
- R6: Whenever `ssN` is high, `sck` equals the cpol bit. With cpha=0 the first bit is on `mosi` before the first `sck` edge, and `miso` is sampled on the first edge of each bit. With cpha=1 `mosi` changes on the first edge of each bit and `miso` is sampled on the second edge.
- R7: After a transfer, a read of the data register returns the byte gathered from `miso`, first bit in the MSB. A data read never starts a transfer.
- R8: The transfer-complete flag is set on the final `sck` edge, while `ssN` is still low. `irqReq` is high exactly when transfer-complete and interrupt enable are both 1.
- R9: A data write while a transfer is still running, including the last half-period before `ssN` rises, sets write-collision. It leaves the outgoing byte and the received byte unchanged.
- R10: A status read records which flags are set. The next data read, or accepted data write, clears exactly those flags. A data access with no status read before it clears nothing, and a status read alone clears nothing.
- R11: Reset clears control and status, ends any transfer with `ssN` high and `sck` at 0, and drops any recorded flag clear.
- R12: `mosi` holds its last value while `ssN` is high. The wire-or and master-select bits are stored and read back but change nothing else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid during a read strobe, otherwise 0 |
| irqReq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 1 | Slave select, active low |

## Verification
The bench uses the default half-period lengths of 1, 2, 8 and 16 clocks and a transfer length of eight bits. Every rate and all four clock modes are therefore exercised within a few hundred cycles per byte. The 16-clock half-period gives enough room to place a collision write in the middle of a byte and to pull reset part way through one. A behavioural slave on the serial lines checks each bit in both directions. The one-clock half-period shows that back-to-back events with no idle cycles between them still sample and drive the right bits.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int XFER_BITS = 8;

  localparam int CB_IRQEN = 7;
  localparam int CB_EN    = 6;
  localparam int CB_CPOL  = 3;
  localparam int CB_CPHA  = 2;

  localparam int SB_DONE  = 7;
  localparam int SB_COLL  = 6;
  localparam int SB_FAULT = 4;

  typedef struct packed {
    logic load;
    logic tick;
    logic sampleBit;
    logic driveBit;
    logic finish;
    logic relSs;
  } xferStrobes_t;

endpackage

// File: rtl/spim_ctl.sv
module spim_ctl
  import spim_pkg::*;
#(
  parameter int HALF_R0 = 1,
  parameter int HALF_R1 = 2,
  parameter int HALF_R2 = 8,
  parameter int HALF_R3 = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busSel,
  input  logic         busWr,
  input  logic [1:0]   busAddr,
  input  logic [7:0]   busWdata,
  output logic [7:0]   ctrlReg,
  output logic [7:0]   statReg,
  output logic         busy,
  output xferStrobes_t strb
);

  localparam int MAX_A    = (HALF_R0 > HALF_R1) ? HALF_R0 : HALF_R1;
  localparam int MAX_B    = (HALF_R2 > HALF_R3) ? HALF_R2 : HALF_R3;
  localparam int MAX_HALF = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W    = ($clog2(MAX_HALF) > 0) ? $clog2(MAX_HALF) : 1;
  localparam int NUM_EVT  = 2 * XFER_BITS;
  localparam int EVT_W    = $clog2(NUM_EVT);
  localparam logic [EVT_W-1:0] LAST_EVT = EVT_W'(NUM_EVT - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} xferState_t;

  xferState_t      state;
  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] reloadVal;
  logic [EVT_W-1:0] evtCnt;
  logic             doneFlag;
  logic             collFlag;
  logic [1:0]       pendClr;

  logic ctrlWr, statRd, dataWr, dataRd, dataAcc;
  logic startXfer, collide, tmrZero, lastEvt;

  assign ctrlWr    = busSel && busWr && (busAddr == ADDR_CTRL);
  assign statRd    = busSel && !busWr && (busAddr == ADDR_STAT);
  assign dataWr    = busSel && busWr && (busAddr == ADDR_DATA);
  assign dataRd    = busSel && !busWr && (busAddr == ADDR_DATA);
  assign dataAcc   = dataRd || (dataWr && ctrlReg[CB_EN]);
  assign busy      = (state != ST_IDLE);
  assign startXfer = dataWr && ctrlReg[CB_EN] && !busy;
  assign collide   = dataWr && ctrlReg[CB_EN] && busy;
  assign tmrZero   = (tmr == '0);
  assign lastEvt   = (evtCnt == LAST_EVT);

  always_comb begin
    case (ctrlReg[1:0])
      2'd0:    reloadVal = TMR_W'(HALF_R0 - 1);
      2'd1:    reloadVal = TMR_W'(HALF_R1 - 1);
      2'd2:    reloadVal = TMR_W'(HALF_R2 - 1);
      default: reloadVal = TMR_W'(HALF_R3 - 1);
    endcase
  end

  // Strobes toward the datapath
  always_comb begin
    strb           = '0;
    strb.load      = startXfer;
    strb.tick      = (state == ST_SHIFT) && tmrZero;
    strb.sampleBit = strb.tick && (ctrlReg[CB_CPHA] ? evtCnt[0] : !evtCnt[0]);
    strb.driveBit  = strb.tick && !strb.sampleBit && !lastEvt;
    strb.finish    = strb.tick && lastEvt;
    strb.relSs     = (state == ST_TAIL) && tmrZero;
  end

  // Sequencer: half-period timer and event counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tmr    <= '0;
      evtCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startXfer) begin
            state  <= ST_SHIFT;
            tmr    <= reloadVal;
            evtCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (tmrZero) begin
            tmr    <= reloadVal;
            evtCnt <= evtCnt + 1'b1;
            if (lastEvt) state <= ST_TAIL;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_TAIL: begin
          if (tmrZero) state <= ST_IDLE;
          else         tmr   <= tmr - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Registers and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      doneFlag <= 1'b0;
      collFlag <= 1'b0;
      pendClr  <= '0;
    end else begin
      if (ctrlWr) ctrlReg <= busWdata;
      if (statRd)       pendClr <= {doneFlag, collFlag};
      else if (dataAcc) pendClr <= '0;
      doneFlag <= (doneFlag && !(dataAcc && pendClr[1])) || strb.finish;
      collFlag <= (collFlag && !(dataAcc && pendClr[0])) || collide;
    end
  end

  always_comb begin
    statReg           = '0;
    statReg[SB_DONE]  = doneFlag;
    statReg[SB_COLL]  = collFlag;
    statReg[SB_FAULT] = 1'b0;
  end

endmodule

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  xferStrobes_t strb,
  input  logic         cpol,
  input  logic         cpha,
  input  logic [7:0]   txByte,
  input  logic         miso,
  output logic         sck,
  output logic         mosi,
  output logic         ssN,
  output logic [7:0]   rxByte
);

  localparam int MSB = XFER_BITS - 1;

  logic [MSB:0] shiftReg;
  logic [MSB:0] shiftNext;
  logic         sckPh;

  assign shiftNext = {shiftReg[MSB-1:0], miso};
  assign sck       = cpol ^ sckPh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sckPh    <= 1'b0;
      mosi     <= 1'b0;
      ssN      <= 1'b1;
      rxByte   <= '0;
    end else begin
      if (strb.load) begin
        shiftReg <= txByte;
        sckPh    <= 1'b0;
        ssN      <= 1'b0;
        if (!cpha) mosi <= txByte[MSB];
      end
      if (strb.tick)      sckPh    <= ~sckPh;
      if (strb.sampleBit) shiftReg <= shiftNext;
      if (strb.driveBit)  mosi     <= shiftReg[MSB];
      if (strb.finish)    rxByte   <= strb.sampleBit ? shiftNext : shiftReg;
      if (strb.relSs)     ssN      <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spim_pkg::*;
#(
  parameter int HALF_R0 = 1,
  parameter int HALF_R1 = 2,
  parameter int HALF_R2 = 8,
  parameter int HALF_R3 = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irqReq,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  output logic       ssN
);

  logic [7:0]   ctrlReg;
  logic [7:0]   statReg;
  logic [7:0]   rxByte;
  logic         busy;
  xferStrobes_t strb;

  spim_ctl #(
    .HALF_R0(HALF_R0), .HALF_R1(HALF_R1), .HALF_R2(HALF_R2), .HALF_R3(HALF_R3)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .ctrlReg(ctrlReg), .statReg(statReg), .busy(busy),
    .strb(strb)
  );

  spim_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cpol(ctrlReg[CB_CPOL]),
    .cpha(ctrlReg[CB_CPHA]), .txByte(busWdata), .miso(miso), .sck(sck),
    .mosi(mosi), .ssN(ssN), .rxByte(rxByte)
  );

  assign irqReq = ctrlReg[CB_IRQEN] && statReg[SB_DONE];

  always_comb begin
    busRdata = '0;
    if (busSel && !busWr) begin
      case (busAddr)
        ADDR_CTRL: busRdata = ctrlReg;
        ADDR_STAT: busRdata = statReg;
        ADDR_DATA: busRdata = rxByte;
        default:   busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/spim_checker.sv
module spim_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       busWr,
  input logic [1:0] busAddr,
  input logic [7:0] ctrlReg,
  input logic [7:0] statReg,
  input logic       busy,
  input logic       ssN,
  input logic       sck,
  input logic       mosi
);

  logic dataWr;
  assign dataWr = busSel && busWr && (busAddr == 2'd2);

  a_r8_done_while_selected: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statReg[7]) |-> !ssN);

  a_r6_idle_clock_level: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssN) |-> (sck == ctrlReg[3]));

  a_r9_collision_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && ctrlReg[6] && busy) |=> statReg[6]);

  a_r3_disabled_write: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !ctrlReg[6] && ssN) |=> ssN);

  a_r12_mosi_holds_idle: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ssN) && ssN) |-> $stable(mosi));

  a_r4_select_tracks_transfer: assert property (@(posedge clk) disable iff (!rstN)
    busy == !ssN);

endmodule

bind spi_byte_master spim_checker u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .ctrlReg(ctrlReg), .statReg(statReg), .busy(busy), .ssN(ssN), .sck(sck),
  .mosi(mosi)
);

// File: tb/spi_byte_master_test.sv
`timescale 1ns/100ps
module spi_byte_master_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irqReq, sck, mosi, ssN;
  logic       miso = 1'b0;

  int checks = 0;
  int fails = 0;

  logic       cpolB = 1'b0;
  logic       cphaB = 1'b0;
  logic [7:0] slaveByte = '0;
  logic [7:0] slaveReg = '0;
  logic [7:0] mosiCap = '0;
  logic       prevSck = 1'b0;

  always #2.5 clk = ~clk;

  spi_byte_master uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq), .sck(sck),
    .mosi(mosi), .miso(miso), .ssN(ssN)
  );

  // Behavioural slave: shifts after each trailing edge, records mosi on sampling edges
  always @(negedge clk) begin
    if (ssN) begin
      slaveReg <= slaveByte;
      miso     <= slaveByte[7];
    end else if (sck !== prevSck) begin
      if ((sck != cpolB) ^ cphaB) mosiCap <= {mosiCap[6:0], mosi};
      if (sck == cpolB) begin
        slaveReg <= {slaveReg[6:0], 1'b0};
        miso     <= slaveReg[6];
      end
    end
    prevSck <= sck;
  end

  // ctrl, tx, slave
  localparam logic [23:0] VEC [6] = '{
    {8'h40, 8'hA5, 8'h3C},
    {8'h44, 8'h96, 8'hC3},
    {8'h79, 8'h5A, 8'h81},
    {8'h4D, 8'hF0, 8'h0F},
    {8'h42, 8'h01, 8'h80},
    {8'h4F, 8'h80, 8'hFE}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  function automatic int halfOf(input logic [1:0] r);
    case (r)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic waitRelease(output int n);
    n = 0;
    while (ssN !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11: reset state
    busRead(2'd0, rd); chk("R11 ctrl after reset", rd, 8'h00);
    busRead(2'd1, rd); chk("R11 status after reset", rd, 8'h00);
    chk("R11 ssN after reset", ssN, 1'b1);
    chk("R11 sck after reset", sck, 1'b0);
    chk("R11 irq after reset", irqReq, 1'b0);
    busRead(2'd3, rd); chk("R1 unused address reads 0", rd, 8'h00);

    // Table of transfers over modes and rates
    foreach (VEC[i]) begin
      logic [7:0] c, tx, sl;
      int h;
      {c, tx, sl} = VEC[i];
      h = halfOf(c[1:0]);
      busWrite(2'd0, c);
      cpolB = c[3]; cphaB = c[2]; slaveByte = sl;
      busRead(2'd0, rd); chk("R1 R12 ctrl readback", rd, c);
      chk("R6 idle sck at cpol", sck, c[3]);
      busWrite(2'd2, tx);
      chk("R4 select low after write", ssN, 1'b0);
      waitRelease(n);
      chk("R4 R5 transfer length", n, 17 * h);
      chk("R4 R6 bits on mosi", mosiCap, tx);
      chk("R6 sck back at cpol", sck, c[3]);
      chk("R12 mosi holds last bit", mosi, tx[0]);
      chk("R8 irq off without enable", irqReq, 1'b0);
      busRead(2'd1, rd); chk("R8 done flag", rd, 8'h80);
      busRead(2'd2, rd); chk("R7 received byte", rd, sl);
      busRead(2'd1, rd); chk("R10 flags cleared", rd, 8'h00);
      busRead(2'd2, rd);
    end

    // R3: disabled write ignored
    busWrite(2'd0, 8'h08);
    busWrite(2'd2, 8'h55);
    n = 0;
    repeat (40) begin
      @(negedge clk);
      if (ssN !== 1'b1) n++;
    end
    chk("R3 no transfer when disabled", n, 0);
    chk("R3 R12 mosi unchanged", mosi, 1'b0);
    busRead(2'd1, rd); chk("R3 status untouched", rd, 8'h00);

    // R7: data read starts nothing
    busWrite(2'd0, 8'h40);
    busRead(2'd2, rd);
    n = 0;
    repeat (20) begin
      @(negedge clk);
      if (ssN !== 1'b1) n++;
    end
    chk("R7 data read starts no transfer", n, 0);

    // R8 R10: interrupt and two-step clear
    busWrite(2'd0, 8'hC1);
    cpolB = 1'b0; cphaB = 1'b0; slaveByte = 8'h6E;
    busWrite(2'd2, 8'h3B);
    waitRelease(n);
    chk("R8 irq with enable", irqReq, 1'b1);
    busRead(2'd2, rd); chk("R7 byte via direct read", rd, 8'h6E);
    chk("R10 data read alone keeps irq", irqReq, 1'b1);
    busWrite(2'd1, 8'h00);
    busRead(2'd1, rd); chk("R2 status write ignored", rd, 8'h80);
    chk("R10 status read alone keeps irq", irqReq, 1'b1);
    busRead(2'd2, rd);
    chk("R10 irq dropped after sequence", irqReq, 1'b0);
    busRead(2'd1, rd); chk("R10 status clear after sequence", rd, 8'h00);

    // R9: collision mid-transfer
    busWrite(2'd0, 8'h43);
    slaveByte = 8'h5A;
    busWrite(2'd2, 8'hC5);
    repeat (40) @(negedge clk);
    busWrite(2'd2, 8'h33);
    waitRelease(n);
    chk("R9 transfer not restarted", n, 17 * 16 - 42);
    chk("R9 outgoing byte unchanged", mosiCap, 8'hC5);
    busRead(2'd1, rd); chk("R9 collision and done flags", rd, 8'hC0);
    busRead(2'd2, rd); chk("R9 received byte intact", rd, 8'h5A);
    busRead(2'd1, rd); chk("R10 both flags cleared", rd, 8'h00);

    // R11: reset in the middle of a transfer
    busWrite(2'd0, 8'h4B);
    cpolB = 1'b1;
    busWrite(2'd2, 8'hE7);
    repeat (30) @(negedge clk);
    chk("R4 select low mid transfer", ssN, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 select released by reset", ssN, 1'b1);
    chk("R11 sck zero after reset", sck, 1'b0);
    busRead(2'd0, rd); chk("R11 ctrl cleared", rd, 8'h00);
    busRead(2'd1, rd); chk("R11 status cleared", rd, 8'h00);

    finishRun();
  end

endmodule